// File: doc/BRIEF.md
# DMA Channel Mask and Mode Control

This block keeps the enable state and the operating mode of each channel of a small DMA engine. It also decides which incoming channel requests go on to the service logic. The host programs it with byte writes on four strobes. Three strobes change the masks: one channel's mask, all masks loaded at once from the data byte, or all masks cleared. The fourth strobe writes a mode byte, and the channel it targets is carried in the low bits of that same byte.

Each channel request takes one of two paths. A request that needs address and count cycles leaves on the service vector. A channel in cascade mode is a pass-through for a downstream controller, so its request leaves on a separate pass vector, and the service logic never runs cycles for it. Terminal count from the transfer engine behaves differently per channel. A plain channel disables itself. An autoinitialize channel stays enabled and raises a one-cycle reload pulse, which the address and count logic uses to restore its start values. Priority arbitration between the forwarded requests is done outside this block.

Top module: `dmc_chan_ctl`

## Requirements
- R1: After reset every channel is masked. `svc_req`, `pass_req` and `reload` are all zero. Every channel's mode reads as demand, verify, increment, no autoinit, so all bits of `dir_out`, `xmode_out`, `auto_out` and `decr_out` are zero.
- R2: A write with `mask_one_we` selects the channel with `wr_data[1:0]` and loads `wr_data[2]` as that channel's mask, where 1 means masked. The new mask takes effect after the clock edge. The other channels are unchanged.
- R3: A write with `mask_all_we` loads the masks from `wr_data[3:0]`, with bit i going to channel i. A write with `mask_clr_we` unmasks every channel. If both strobes are high in the same cycle, the clear wins.
- R4: A write with `mode_we` selects the channel with `wr_data[1:0]` and stores the mode byte into that channel's fields, visible after the edge. `wr_data[7:6]` sets the transfer mode (00 demand, 01 single, 10 block, 11 cascade). `wr_data[5]` sets decrement, `wr_data[4]` sets autoinitialize, and `wr_data[3:2]` sets the direction (00 verify, 01 I/O to memory, 10 memory to I/O). Channel i uses bits [2i+1:2i] of `xmode_out` and `dir_out`, and bit i of `auto_out` and `decr_out`.
- R5: In the same cycle, `svc_req[i]` is 1 exactly when `dreq[i]` is 1, channel i is unmasked, and channel i is not in cascade mode.
- R6: In the same cycle, `pass_req[i]` is 1 exactly when `dreq[i]` is 1, channel i is unmasked, and channel i is in cascade mode. A cascade channel never raises `svc_req`.
- R7: Suppose an unmasked, non-cascade channel without autoinit sees `tc` high. It is masked after that edge and gives no reload pulse.
- R8: Suppose an unmasked, non-cascade channel with autoinit sees `tc` high. Its `reload` bit is high for exactly the cycle after that edge, and the channel stays unmasked.
- R9: `tc` has no effect on a channel that is masked or in cascade mode. Its mask, its requests and its `reload` bit stay unchanged.
- R10: A host mask write that touches a channel takes precedence over that channel's terminal count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_one_we | input | 1 | Single-channel mask write strobe |
| mask_all_we | input | 1 | Load-all-masks write strobe |
| mask_clr_we | input | 1 | Clear-all-masks write strobe |
| mode_we | input | 1 | Mode write strobe |
| wr_data | input | 8 | Host write data |
| dreq | input | NUM_CH | Channel requests |
| tc | input | NUM_CH | Terminal count per channel |
| svc_req | output | NUM_CH | Requests needing transfer cycles |
| pass_req | output | NUM_CH | Cascade pass-through requests |
| reload | output | NUM_CH | Autoinitialize reload pulse |
| dir_out | output | 2*NUM_CH | Direction field per channel |
| xmode_out | output | 2*NUM_CH | Transfer mode field per channel |
| auto_out | output | NUM_CH | Autoinitialize flag per channel |
| decr_out | output | NUM_CH | Decrement flag per channel |

## Verification
The bench goes after several corner cases.
- Clear and load-all in the same cycle. A design with the wrong priority would leave channels masked.
- A host unmask that lands on the same edge as a terminal count. If the count wins, the channel goes silent.
- Terminal count on an autoinitialize channel. A design that masks it, or stretches or drops the reload pulse, is caught on `svc_req` and `reload`.
- Terminal count on masked and cascade channels. A design that does not ignore it would raise a stray reload or kill the pass-through.
- A reset in the middle of the run. Mode bits that survive it show up on the field outputs.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   localparam int SEL_W  = 2;
   localparam int MODE_W = 6;
   localparam int MAX_CH = 4;

   typedef enum logic [1:0] {
      XM_DEMAND  = 2'b00,
      XM_SINGLE  = 2'b01,
      XM_BLOCK   = 2'b10,
      XM_CASCADE = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      DIR_VERIFY   = 2'b00,
      DIR_TO_MEM   = 2'b01,
      DIR_FROM_MEM = 2'b10,
      DIR_RSVD     = 2'b11
   } dir_e;

   typedef struct packed {
      xfer_mode_e xm;
      logic       decr;
      logic       autoinit;
      dir_e       dir;
   } chan_mode_t;

   function automatic logic is_cascade(input chan_mode_t m);
      return m.xm == XM_CASCADE;
   endfunction

endpackage

// File: rtl/dmc_mask_bank.sv
module dmc_mask_bank
   import dmc_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter bit HOST_OVER_TC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              set_all,
   input  logic              set_one,
   input  logic [SEL_W-1:0]  one_sel,
   input  logic              one_val,
   input  logic [NUM_CH-1:0] all_val,
   input  logic [NUM_CH-1:0] tc_set,
   output logic [NUM_CH-1:0] mask_q
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic host_hit;
      logic host_val;
      logic bit_q;

      // host write decode: clear beats load-all beats single
      always_comb begin
         host_hit = 1'b0;
         host_val = bit_q;
         if (clr_all) begin
            host_hit = 1'b1;
            host_val = 1'b0;
         end else if (set_all) begin
            host_hit = 1'b1;
            host_val = all_val[i];
         end else if (set_one && (one_sel == SEL_W'(i))) begin
            host_hit = 1'b1;
            host_val = one_val;
         end
      end

      if (HOST_OVER_TC) begin : g_host_first
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b1;
            else if (host_hit)
               bit_q <= host_val;
            else if (tc_set[i])
               bit_q <= 1'b1;
         end
      end else begin : g_tc_first
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b1;
            else if (tc_set[i])
               bit_q <= 1'b1;
            else if (host_hit)
               bit_q <= host_val;
         end
      end

      assign mask_q[i] = bit_q;
   end

endmodule

// File: rtl/dmc_mode_bank.sv
module dmc_mode_bank
   import dmc_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [MODE_W-1:0]   wr_field,
   output logic [NUM_CH-1:0]   casc,
   output logic [NUM_CH-1:0]   autoi,
   output logic [NUM_CH-1:0]   decr,
   output logic [2*NUM_CH-1:0] dir_flat,
   output logic [2*NUM_CH-1:0] xm_flat
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_mode_t mode_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            mode_q <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            mode_q <= chan_mode_t'(wr_field);
      end

      assign casc[i]          = is_cascade(mode_q);
      assign autoi[i]         = mode_q.autoinit;
      assign decr[i]          = mode_q.decr;
      assign dir_flat[2*i+:2] = mode_q.dir;
      assign xm_flat[2*i+:2]  = mode_q.xm;
   end

endmodule

// File: rtl/dmc_tc_ctl.sv
module dmc_tc_ctl #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tc,
   input  logic [NUM_CH-1:0] mask_q,
   input  logic [NUM_CH-1:0] casc,
   input  logic [NUM_CH-1:0] autoi,
   output logic [NUM_CH-1:0] tc_set,
   output logic [NUM_CH-1:0] reload
);

   logic [NUM_CH-1:0] live;
   logic [NUM_CH-1:0] reload_q;

   // terminal count only matters on an active, non-pass-through channel
   assign live   = tc & ~mask_q & ~casc;
   assign tc_set = live & ~autoi;

   always_ff @(posedge clk) begin
      if (!rst_n)
         reload_q <= '0;
      else
         reload_q <= live & autoi;
   end

   assign reload = reload_q;

endmodule

// File: rtl/dmc_req_gate.sv
module dmc_req_gate #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] dreq,
   input  logic [NUM_CH-1:0] mask_q,
   input  logic [NUM_CH-1:0] casc,
   output logic [NUM_CH-1:0] svc_req,
   output logic [NUM_CH-1:0] pass_req
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic open_c;
      assign open_c      = dreq[i] & ~mask_q[i];
      assign svc_req[i]  = open_c & ~casc[i];
      assign pass_req[i] = open_c &  casc[i];
   end

endmodule

// File: rtl/dmc_chan_ctl.sv
module dmc_chan_ctl
   import dmc_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter bit HOST_OVER_TC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mask_one_we,
   input  logic                mask_all_we,
   input  logic                mask_clr_we,
   input  logic                mode_we,
   input  logic [7:0]          wr_data,
   input  logic [NUM_CH-1:0]   dreq,
   input  logic [NUM_CH-1:0]   tc,
   output logic [NUM_CH-1:0]   svc_req,
   output logic [NUM_CH-1:0]   pass_req,
   output logic [NUM_CH-1:0]   reload,
   output logic [2*NUM_CH-1:0] dir_out,
   output logic [2*NUM_CH-1:0] xmode_out,
   output logic [NUM_CH-1:0]   auto_out,
   output logic [NUM_CH-1:0]   decr_out
);

   localparam int VAL_BIT = SEL_W;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("dmc_chan_ctl: NUM_CH must lie in 1..4");
   end
   if (SEL_W + MODE_W != 8) begin : g_bad_fmt
      $error("dmc_chan_ctl: select and mode fields must fill one byte");
   end

   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] casc;
   logic [NUM_CH-1:0] autoi;
   logic [NUM_CH-1:0] tc_set;

   dmc_mask_bank #(
      .NUM_CH       (NUM_CH),
      .HOST_OVER_TC (HOST_OVER_TC)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (mask_clr_we),
      .set_all (mask_all_we),
      .set_one (mask_one_we),
      .one_sel (wr_data[SEL_W-1:0]),
      .one_val (wr_data[VAL_BIT]),
      .all_val (wr_data[NUM_CH-1:0]),
      .tc_set  (tc_set),
      .mask_q  (mask_q)
   );

   dmc_mode_bank #(
      .NUM_CH (NUM_CH)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mode_we),
      .wr_sel   (wr_data[SEL_W-1:0]),
      .wr_field (wr_data[7:SEL_W]),
      .casc     (casc),
      .autoi    (autoi),
      .decr     (decr_out),
      .dir_flat (dir_out),
      .xm_flat  (xmode_out)
   );

   dmc_tc_ctl #(
      .NUM_CH (NUM_CH)
   ) u_tc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tc     (tc),
      .mask_q (mask_q),
      .casc   (casc),
      .autoi  (autoi),
      .tc_set (tc_set),
      .reload (reload)
   );

   dmc_req_gate #(
      .NUM_CH (NUM_CH)
   ) u_gate (
      .dreq     (dreq),
      .mask_q   (mask_q),
      .casc     (casc),
      .svc_req  (svc_req),
      .pass_req (pass_req)
   );

   assign auto_out = autoi;

endmodule

// File: rtl/dmc_chan_ctl_chk.sv
module dmc_chan_ctl_chk #(
   parameter int NUM_CH = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mask_one_we,
   input logic                mask_all_we,
   input logic                mask_clr_we,
   input logic [NUM_CH-1:0]   dreq,
   input logic [NUM_CH-1:0]   tc,
   input logic [NUM_CH-1:0]   svc_req,
   input logic [NUM_CH-1:0]   pass_req,
   input logic [NUM_CH-1:0]   reload,
   input logic [NUM_CH-1:0]   mask_q,
   input logic [NUM_CH-1:0]   auto_out,
   input logic [2*NUM_CH-1:0] xmode_out
);

   logic host_wr;
   assign host_wr = mask_one_we | mask_all_we | mask_clr_we;

   p_svc_needs_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req & ~dreq) == '0);

   p_paths_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req & pass_req) == '0);

   p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_clr_we |=> (mask_q == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic casc_c;
      assign casc_c = (xmode_out[2*i+:2] == 2'b11);

      p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q[i] |-> (!svc_req[i] && !pass_req[i]));

      p_cascade_no_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
         casc_c |-> !svc_req[i]);

      p_tc_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (tc[i] && !mask_q[i] && !casc_c && !auto_out[i] && !host_wr) |=> mask_q[i]);

      p_autoinit_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (tc[i] && !mask_q[i] && !casc_c && auto_out[i] && !host_wr)
            |=> (reload[i] && !mask_q[i]));

      p_reload_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
         reload[i] |-> $past(tc[i]));
   end

endmodule

bind dmc_chan_ctl dmc_chan_ctl_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mask_one_we (mask_one_we),
   .mask_all_we (mask_all_we),
   .mask_clr_we (mask_clr_we),
   .dreq        (dreq),
   .tc          (tc),
   .svc_req     (svc_req),
   .pass_req    (pass_req),
   .reload      (reload),
   .mask_q      (mask_q),
   .auto_out    (auto_out),
   .xmode_out   (xmode_out)
);

// File: tb/dmc_chan_ctl_tb.sv
module dmc_chan_ctl_tb;

   localparam int CLK_P = 10;
   localparam int NV    = 22;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mask_one_we, mask_all_we, mask_clr_we, mode_we;
   logic [7:0] wr_data;
   logic [3:0] dreq, tc;
   logic [3:0] svc_req, pass_req, reload, auto_out, decr_out;
   logic [7:0] dir_out, xmode_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   dmc_chan_ctl u_dut (
      .clk(clk), .rst_n(rst_n),
      .mask_one_we(mask_one_we), .mask_all_we(mask_all_we),
      .mask_clr_we(mask_clr_we), .mode_we(mode_we),
      .wr_data(wr_data), .dreq(dreq), .tc(tc),
      .svc_req(svc_req), .pass_req(pass_req), .reload(reload),
      .dir_out(dir_out), .xmode_out(xmode_out),
      .auto_out(auto_out), .decr_out(decr_out)
   );

   // {strobes clr/all/one/mode, data, dreq, tc, exp svc, exp pass, exp reload, req}
   localparam logic [35:0] VEC [NV] = '{
      {4'b0000, 8'h00, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'd1 },  // R1 masked out of reset
      {4'b1000, 8'h00, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'd3 },  // R3 clear all
      {4'b0010, 8'h05, 4'hF, 4'h0, 4'hD, 4'h0, 4'h0, 4'd2 },  // R2 mask ch1
      {4'b0010, 8'h01, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'd2 },  // R2 unmask ch1
      {4'b0100, 8'h0A, 4'hF, 4'h0, 4'h5, 4'h0, 4'h0, 4'd3 },  // R3 load all
      {4'b1100, 8'h0F, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'd3 },  // R3 clear beats load
      {4'b0001, 8'hC2, 4'hF, 4'h0, 4'hB, 4'h4, 4'h0, 4'd6 },  // R6 ch2 cascade
      {4'b0000, 8'h00, 4'h6, 4'h0, 4'h2, 4'h4, 4'h0, 4'd5 },  // R5 sparse dreq
      {4'b0001, 8'h54, 4'hF, 4'h0, 4'hB, 4'h4, 4'h0, 4'd4 },  // R4 ch0 single auto
      {4'b0000, 8'h00, 4'hF, 4'h1, 4'hB, 4'h4, 4'h1, 4'd8 },  // R8 reload, stays open
      {4'b0000, 8'h00, 4'hF, 4'h0, 4'hB, 4'h4, 4'h0, 4'd8 },  // R8 one-cycle pulse
      {4'b0000, 8'h00, 4'hF, 4'h2, 4'h9, 4'h4, 4'h0, 4'd7 },  // R7 ch1 self-masks
      {4'b0000, 8'h00, 4'hF, 4'h2, 4'h9, 4'h4, 4'h0, 4'd9 },  // R9 tc on masked
      {4'b0000, 8'h00, 4'hF, 4'h4, 4'h9, 4'h4, 4'h0, 4'd9 },  // R9 tc on cascade
      {4'b0010, 8'h01, 4'hF, 4'h0, 4'hB, 4'h4, 4'h0, 4'd2 },  // R2 unmask ch1
      {4'b0010, 8'h01, 4'hF, 4'h2, 4'hB, 4'h4, 4'h0, 4'd10},  // R10 host beats tc
      {4'b0010, 8'h05, 4'hF, 4'h0, 4'h9, 4'h4, 4'h0, 4'd2 },  // R2 mask ch1
      {4'b0001, 8'h55, 4'hF, 4'h0, 4'h9, 4'h4, 4'h0, 4'd4 },  // R4 ch1 auto
      {4'b0000, 8'h00, 4'hF, 4'h2, 4'h9, 4'h4, 4'h0, 4'd9 },  // R9 masked auto no reload
      {4'b1000, 8'h00, 4'hF, 4'h0, 4'hB, 4'h4, 4'h0, 4'd3 },  // R3 clear all
      {4'b0000, 8'h00, 4'hF, 4'hB, 4'h3, 4'h4, 4'h3, 4'd7 },  // R7 ch3 masks, ch0/1 reload
      {4'b0000, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'd5 }   // R5 no dreq
   };

   task automatic chk(input int rq, input string nm, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, nm, act, exp);
      end
   endtask

   task automatic idle_inputs();
      mask_one_we = 1'b0; mask_all_we = 1'b0; mask_clr_we = 1'b0; mode_we = 1'b0;
      wr_data = 8'h00; tc = 4'h0;
   endtask

   initial begin
      #(CLK_P * 20000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      dreq = 4'hF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 mode fields after reset
      chk(1, "dir_out",   dir_out,   8'h00);
      chk(1, "xmode_out", xmode_out, 8'h00);
      chk(1, "auto_out",  {4'h0, auto_out}, 8'h00);
      chk(1, "decr_out",  {4'h0, decr_out}, 8'h00);

      for (int k = 0; k < NV; k++) begin
         {mask_clr_we, mask_all_we, mask_one_we, mode_we} = VEC[k][35:32];
         wr_data = VEC[k][31:24];
         dreq    = VEC[k][23:20];
         tc      = VEC[k][19:16];
         @(posedge clk);
         @(negedge clk);
         chk(int'(VEC[k][3:0]), "svc_req",  {4'h0, svc_req},  {4'h0, VEC[k][15:12]});
         chk(int'(VEC[k][3:0]), "pass_req", {4'h0, pass_req}, {4'h0, VEC[k][11:8]});
         chk(int'(VEC[k][3:0]), "reload",   {4'h0, reload},   {4'h0, VEC[k][7:4]});
      end
      idle_inputs();

      // R4 decoded fields: ch0/ch1 single+auto+to-mem, ch2 cascade, ch3 default
      chk(4, "dir_out",   dir_out,   8'h05);
      chk(4, "xmode_out", xmode_out, 8'h35);
      chk(4, "auto_out",  {4'h0, auto_out}, 8'h03);
      chk(4, "decr_out",  {4'h0, decr_out}, 8'h00);

      // R4 ch3 demand, decrement, memory to I/O; others unchanged
      mode_we = 1'b1; wr_data = 8'h2B;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      chk(4, "dir_out ch3",   dir_out,   8'h85);
      chk(4, "xmode_out ch3", xmode_out, 8'h35);
      chk(4, "decr_out ch3",  {4'h0, decr_out}, 8'h08);
      chk(4, "auto_out ch3",  {4'h0, auto_out}, 8'h03);

      // R1 reset in mid-run
      dreq = 4'hF;
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(1, "svc_req rst",   {4'h0, svc_req},  8'h00);
      chk(1, "pass_req rst",  {4'h0, pass_req}, 8'h00);
      chk(1, "reload rst",    {4'h0, reload},   8'h00);
      chk(1, "dir_out rst",   dir_out,   8'h00);
      chk(1, "xmode_out rst", xmode_out, 8'h00);
      chk(1, "auto_out rst",  {4'h0, auto_out}, 8'h00);
      chk(1, "decr_out rst",  {4'h0, decr_out}, 8'h00);
      @(negedge clk);
      chk(1, "svc_req held", {4'h0, svc_req}, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule